// File: doc/BRIEF.md
# Programmable Interrupt Controller Command Sequencer

This block is the host-facing side of an eight-line programmable interrupt controller. A host reaches it through a one-bit address and an eight-bit data port with single-cycle write and read strobes. Writes are decoded into initialization words, which run a short multi-word setup sequence, and into operation commands, which change read-back selection, polling, special masking, end-of-interrupt handling and priority rotation. The block holds the mask, the in-service set, the rotation base, the vector base and the mode flags.

Pending requests come from a neighbouring request latch on `req_i`. A rotating priority finder, instantiated three times, ranks unmasked requests and in-service lines against the rotation base. `int_o` is raised when the best unmasked request outranks the best in-service line. On an acknowledge strobe, or on a read while polling is armed, the winning line is taken: `ack_o` and `ack_line_o` tell the latch which line to drop, and the in-service set or the rotation base is updated. During an acknowledge the vector is the vector base with the line number in its low three bits.

Top module: `icu_cmd_seq`

## Requirements
- R1: After reset the mask, in-service set, rotation base, vector base and all mode flags are zero, the sequencer is idle, and a write to address 1 loads the mask.
- R2: A write to address 0 with bit 4 set clears mask, in-service set, rotation base, vector base and all flags, records bit 0 as "fourth word wanted" and bit 1 as "single unit", and makes the next address-1 write the vector base.
- R3: Setup sequence on address-1 writes: the vector base word keeps data bits 7:3. Then the cascade word follows unless single unit. Then the mode word follows if a fourth word was wanted; in it bit 4 sets `nested_o` and bit 1 sets auto end-of-interrupt. After the last word, address-1 writes load the mask again.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a mode command: bit 2 arms polling. If bit 1 is set, bit 0 picks the address-0 read (1 = in-service, 0 = pending). If bit 6 is set, bit 5 turns special masking on or off.
- R5: Priority rotates: line (base + k) mod 8 has rank k, with rank 0 highest. `int_o` is high when the best unmasked pending line has a smaller rank than the best in-service line; with special masking on, masked in-service lines are left out of that comparison.
- R6: During an acknowledge strobe with a winner, `vector_o` = vector base OR line, `ack_o` is high and `ack_line_o` = line. The line's in-service bit is set, unless auto end-of-interrupt is on; in that case the in-service set is untouched and, if rotate-on-auto-end is on, the base becomes line + 1.
- R7: An acknowledge with no winner gives vector base OR 7, keeps `ack_o` low and changes no state.
- R8: Operation code in bits 7:5 = 1 clears the highest-ranked in-service bit; code 5 does the same and then sets the base to that line + 1.
- R9: Code 3 clears in-service bit (data & 7); code 7 clears it and sets the base to that line + 1.
- R10: Code 6 sets the base to (data + 1) & 7; codes 0 and 4 set rotate-on-auto-end to bit 7 of the data; code 2 changes nothing.
- R11: A read while polling is armed takes the winner as an acknowledge does and returns 0x80 OR line, or 0 with no winner; polling is then disarmed.
- R12: A normal read of address 0 returns the in-service set or `req_i` as selected by R4; address 1 returns the mask. `rdata_o` is 0 when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| req_i | input | 8 | Pending requests from the request latch |
| rdata_o | output | 8 | Read data during a read strobe |
| int_o | output | 1 | Interrupt request to the host |
| vector_o | output | 8 | Vector during an acknowledge strobe |
| ack_o | output | 1 | A line is being taken this cycle |
| ack_line_o | output | 3 | Line being taken |
| nested_o | output | 1 | Nested-mode flag from the mode word |

## Verification
`rdata_o`, `vector_o`, `ack_o` and `ack_line_o` are combinational and due in the same cycle as their strobe, while every register change from a write, poll read or acknowledge shows from the cycle after the strobe's clock edge. The bench drives strobes one time unit after a rising edge and compares every output at the following falling edge against a behavioural model; the model applies the strobe's state effect only after that comparison, so each result is checked in the cycle where it is due. Effects with no output of their own, such as the setup sequence and the no-op code, are checked through later mask, in-service and vector reads.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned LW    = $clog2(LINES);
  localparam int unsigned DW    = 8;
  localparam int unsigned NFIND = 3;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_VBASE = 2'd1,
    ST_CASC  = 2'd2,
    ST_MODE  = 2'd3
  } init_st_e;
endpackage

// File: rtl/icu_prio_find.sv
module icu_prio_find #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] mask_i,
  input  logic [W-1:0] base_i,
  output logic         found_o,
  output logic [W-1:0] rank_o,
  output logic [W-1:0] line_o
);
  // scan from lowest priority up so the highest-ranked set bit wins
  always_comb begin
    logic [W-1:0] idx;
    found_o = 1'b0;
    rank_o  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = W'(k) + base_i;
      if (mask_i[idx]) begin
        found_o = 1'b1;
        rank_o  = W'(k);
      end
    end
  end

  assign line_o = rank_o + base_i;
endmodule

// File: rtl/icu_init_fsm.sv
module icu_init_fsm
  import icu_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     need4_i,
  input  logic     single_i,
  input  logic     adv_i,
  output init_st_e st_o
);
  init_st_e st_q, st_d;
  logic     need4_q, single_q;

  always_comb begin
    unique case (st_q)
      ST_VBASE: st_d = single_q ? (need4_q ? ST_MODE : ST_READY) : ST_CASC;
      ST_CASC:  st_d = need4_q ? ST_MODE : ST_READY;
      default:  st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_READY;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_VBASE;
      need4_q  <= need4_i;
      single_q <= single_i;
    end else if (adv_i && st_q != ST_READY) begin
      st_q <= st_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/icu_cmd_seq.sv
module icu_cmd_seq
  import icu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          inta_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [LINES-1:0] req_i,
  output logic [DW-1:0] rdata_o,
  output logic          int_o,
  output logic [DW-1:0] vector_o,
  output logic          ack_o,
  output logic [LW-1:0] ack_line_o,
  output logic          nested_o
);
  logic [LINES-1:0] imr_q, isr_q;
  logic [LW-1:0]    rot_q;
  logic [DW-LW-1:0] vbase_q;
  logic aeoi_q, raeoi_q, nested_q, rsel_q, poll_q, smask_q;
  init_st_e init_st;

  // command decode
  logic wr0, wr1, icw1, ocw3, ocw2;
  logic [2:0] code;
  assign wr0  = wr_i & ~addr_i;
  assign wr1  = wr_i & addr_i;
  assign icw1 = wr0 & wdata_i[4];
  assign ocw3 = wr0 & ~wdata_i[4] & wdata_i[3];
  assign ocw2 = wr0 & ~wdata_i[4] & ~wdata_i[3];
  assign code = wdata_i[7:5];

  icu_init_fsm i_init_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (icw1),
    .need4_i (wdata_i[0]),
    .single_i(wdata_i[1]),
    .adv_i   (wr1),
    .st_o    (init_st)
  );

  // finder 0: unmasked requests, 1: in-service for comparison, 2: raw in-service for EOI
  logic [LINES-1:0] pmask [NFIND];
  logic             pfound [NFIND];
  logic [LW-1:0]    prank [NFIND];
  logic [LW-1:0]    pline [NFIND];

  assign pmask[0] = req_i & ~imr_q;
  assign pmask[1] = smask_q ? (isr_q & ~imr_q) : isr_q;
  assign pmask[2] = isr_q;

  for (genvar g = 0; g < NFIND; g++) begin : g_find
    icu_prio_find #(.N(LINES)) i_find (
      .mask_i (pmask[g]),
      .base_i (rot_q),
      .found_o(pfound[g]),
      .rank_o (prank[g]),
      .line_o (pline[g])
    );
  end

  logic winner, rd_en, ak_en, poll_rd, take;
  assign winner  = pfound[0] & (~pfound[1] | (prank[0] < prank[1]));
  // precedence: write, then read, then acknowledge
  assign rd_en   = rd_i & ~wr_i;
  assign ak_en   = inta_i & ~wr_i & ~rd_i;
  assign poll_rd = rd_en & poll_q;
  assign take    = winner & (poll_rd | ak_en);

  assign int_o      = winner;
  assign ack_o      = take;
  assign ack_line_o = pline[0];
  assign nested_o   = nested_q;
  assign vector_o   = ak_en ? {vbase_q, winner ? pline[0] : {LW{1'b1}}} : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (poll_q)      rdata_o = winner ? {1'b1, {(DW-1-LW){1'b0}}, pline[0]} : '0;
      else if (addr_i) rdata_o = imr_q;
      else             rdata_o = rsel_q ? isr_q : req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q <= '0; isr_q <= '0; rot_q <= '0; vbase_q <= '0;
      aeoi_q <= 1'b0; raeoi_q <= 1'b0; nested_q <= 1'b0;
      rsel_q <= 1'b0; poll_q <= 1'b0; smask_q <= 1'b0;
    end else if (icw1) begin
      imr_q <= '0; isr_q <= '0; rot_q <= '0; vbase_q <= '0;
      aeoi_q <= 1'b0; raeoi_q <= 1'b0; nested_q <= 1'b0;
      rsel_q <= 1'b0; poll_q <= 1'b0; smask_q <= 1'b0;
    end else if (ocw3) begin
      if (wdata_i[2]) poll_q  <= 1'b1;
      if (wdata_i[1]) rsel_q  <= wdata_i[0];
      if (wdata_i[6]) smask_q <= wdata_i[5];
    end else if (ocw2) begin
      unique case (code)
        3'd0, 3'd4: raeoi_q <= code[2];
        3'd1, 3'd5: if (pfound[2]) begin
          isr_q[pline[2]] <= 1'b0;
          if (code[2]) rot_q <= pline[2] + LW'(1);
        end
        3'd3: isr_q[wdata_i[LW-1:0]] <= 1'b0;
        3'd6: rot_q <= wdata_i[LW-1:0] + LW'(1);
        3'd7: begin
          isr_q[wdata_i[LW-1:0]] <= 1'b0;
          rot_q <= wdata_i[LW-1:0] + LW'(1);
        end
        default: ;
      endcase
    end else if (wr1) begin
      unique case (init_st)
        ST_READY: imr_q <= wdata_i;
        ST_VBASE: vbase_q <= wdata_i[DW-1:LW];
        ST_MODE: begin
          nested_q <= wdata_i[4];
          aeoi_q   <= wdata_i[1];
        end
        default: ;
      endcase
    end else begin
      if (poll_rd) poll_q <= 1'b0;
      if (take) begin
        if (aeoi_q) begin
          if (raeoi_q) rot_q <= pline[0] + LW'(1);
        end else begin
          isr_q[pline[0]] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/icu_cmd_seq_chk.sv
module icu_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic       inta_i,
  input logic       addr_i,
  input logic       init_cmd_i,
  input logic [7:0] req_i,
  input logic       int_o,
  input logic [2:0] vec_lo_i,
  input logic       ack_o,
  input logic [2:0] ack_line_o,
  input logic [1:0] init_st,
  input logic [7:0] imr_q,
  input logic [7:0] isr_q,
  input logic       poll_q,
  input logic       aeoi_q
);
  AST_INIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_cmd_i |=> (imr_q == 8'h00 && isr_q == 8'h00 && init_st == 2'd1)); // R2

  AST_VBASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && init_st == 2'd1) |=> init_st != 2'd1); // R3

  AST_ACK_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (req_i[ack_line_o] && !imr_q[ack_line_o] && int_o)); // R6

  AST_ISR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !aeoi_q) |=> isr_q[$past(ack_line_o)]); // R6

  AST_AEOI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && aeoi_q) |=> $stable(isr_q)); // R6

  AST_SPURIOUS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !wr_i && !rd_i && !int_o) |-> (vec_lo_i == 3'd7 && !ack_o)); // R7

  AST_POLL_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && poll_q) |=> !poll_q); // R11
endmodule

bind icu_cmd_seq icu_cmd_seq_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .inta_i    (inta_i),
  .addr_i    (addr_i),
  .init_cmd_i(wr_i & ~addr_i & wdata_i[4]),
  .req_i     (req_i),
  .int_o     (int_o),
  .vec_lo_i  (vector_o[2:0]),
  .ack_o     (ack_o),
  .ack_line_o(ack_line_o),
  .init_st   (init_st),
  .imr_q     (imr_q),
  .isr_q     (isr_q),
  .poll_q    (poll_q),
  .aeoi_q    (aeoi_q)
);

// File: tb/test_icu_cmd_seq.sv
module test_icu_cmd_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, inta_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = '0, req_i = '0;
  logic [7:0] rdata_o, vector_o;
  logic       int_o, ack_o, nested_o;
  logic [2:0] ack_line_o;

  always #4 clk_i = ~clk_i;

  icu_cmd_seq i_icu_cmd_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .inta_i(inta_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .req_i(req_i), .rdata_o(rdata_o),
    .int_o(int_o), .vector_o(vector_o), .ack_o(ack_o), .ack_line_o(ack_line_o),
    .nested_o(nested_o)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference state
  int m_imr, m_isr, m_rot, m_vbase, m_aeoi, m_raeoi, m_nested;
  int m_rsel, m_poll, m_smask, m_st, m_need4, m_single;

  task automatic model_clear();
    m_imr = 0; m_isr = 0; m_rot = 0; m_vbase = 0; m_aeoi = 0; m_raeoi = 0;
    m_nested = 0; m_rsel = 0; m_poll = 0; m_smask = 0;
  endtask

  function automatic int rank_of(int mask, int base);
    for (int p = 0; p < 8; p++)
      if (((mask >> ((p + base) % 8)) & 1) != 0) return p;
    return 8;
  endfunction

  function automatic int pick();
    int pr, pc;
    pr = rank_of(int'(req_i) & ~m_imr & 255, m_rot);
    if (pr == 8) return -1;
    pc = rank_of(m_smask != 0 ? (m_isr & ~m_imr & 255) : m_isr, m_rot);
    return (pr < pc) ? (pr + m_rot) % 8 : -1;
  endfunction

  task automatic model_take(int l);
    if (m_aeoi != 0) begin
      if (m_raeoi != 0) m_rot = (l + 1) % 8;
    end else m_isr = m_isr | (1 << l);
  endtask

  task automatic model_write(int a, int d);
    int c, p, l;
    if (a == 0) begin
      if ((d & 16) != 0) begin
        model_clear(); m_st = 1; m_need4 = d & 1; m_single = (d >> 1) & 1;
      end else if ((d & 8) != 0) begin
        if ((d & 4) != 0) m_poll = 1;
        if ((d & 2) != 0) m_rsel = d & 1;
        if ((d & 64) != 0) m_smask = (d >> 5) & 1;
      end else begin
        c = d >> 5;
        if (c == 0 || c == 4) m_raeoi = c >> 2;
        else if (c == 1 || c == 5) begin
          p = rank_of(m_isr, m_rot);
          if (p != 8) begin
            l = (p + m_rot) % 8;
            m_isr = m_isr & ~(1 << l);
            if (c == 5) m_rot = (l + 1) % 8;
          end
        end else if (c == 3) m_isr = m_isr & ~(1 << (d & 7));
        else if (c == 6) m_rot = (d + 1) & 7;
        else if (c == 7) begin
          m_isr = m_isr & ~(1 << (d & 7)); m_rot = (d + 1) & 7;
        end
      end
    end else begin
      case (m_st)
        0: m_imr = d;
        1: begin m_vbase = d & 248; m_st = (m_single != 0) ? ((m_need4 != 0) ? 3 : 0) : 2; end
        2: m_st = (m_need4 != 0) ? 3 : 0;
        default: begin m_nested = (d >> 4) & 1; m_aeoi = (d >> 1) & 1; m_st = 0; end
      endcase
    end
  endtask

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare at the falling edge, then advance the model to the next rising edge
  always @(negedge clk_i) begin : mdl
    int w, e;
    if (!rst_ni) begin
      model_clear(); m_st = 0; m_need4 = 0; m_single = 0;
    end else begin
      w = pick();
      check("int_o", int'(int_o), (w >= 0) ? 1 : 0);
      check("nested_o", int'(nested_o), m_nested);
      if (wr_i) begin
        model_write(int'(addr_i), int'(wdata_i));
      end else if (rd_i) begin
        if (m_poll != 0) begin
          e = (w >= 0) ? (128 | w) : 0;
          check("ack_o", int'(ack_o), (w >= 0) ? 1 : 0);
          if (w >= 0) model_take(w);
          m_poll = 0;
        end else if (addr_i) e = m_imr;
        else e = (m_rsel != 0) ? m_isr : int'(req_i);
        check("rdata_o", int'(rdata_o), e);
      end else if (inta_i) begin
        check("vector_o", int'(vector_o), m_vbase + ((w >= 0) ? w : 7));
        check("ack_o", int'(ack_o), (w >= 0) ? 1 : 0);
        if (w >= 0) begin
          check("ack_line_o", int'(ack_line_o), w);
          model_take(w);
        end
      end else begin
        check("rdata_o idle", int'(rdata_o), 0);
        check("vector_o idle", int'(vector_o), 0);
      end
    end
  end

  task automatic wr(logic a, logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic rd(logic a);
    rd_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic ack();
    inta_i = 1'b1;
    @(posedge clk_i); #1;
    inta_i = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    tag = "R1"; rd(1'b1); rd(1'b0); req_i = 8'h01; idle(); req_i = 8'h00; idle();
    tag = "R2"; wr(1'b0, 8'h11); rd(1'b1);
    tag = "R3"; wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h10);
    wr(1'b1, 8'hF0); rd(1'b1);
    tag = "R5"; req_i = 8'h3C; idle();
    tag = "R6"; ack();
    tag = "R4"; wr(1'b0, 8'h0B); rd(1'b0);
    tag = "R12"; wr(1'b0, 8'h0A); rd(1'b0); rd(1'b1);
    tag = "R8"; wr(1'b0, 8'h20); ack(); wr(1'b0, 8'hA0); ack();
    tag = "R9"; wr(1'b0, 8'h63); ack(); wr(1'b0, 8'hE3); ack(); wr(1'b0, 8'h62);
    tag = "R10"; wr(1'b0, 8'hC1); ack(); wr(1'b0, 8'h40); wr(1'b0, 8'h0B); rd(1'b0);
    wr(1'b0, 8'h80); ack(); wr(1'b0, 8'h0B); rd(1'b0);
    tag = "R5"; wr(1'b0, 8'h62); wr(1'b1, 8'hF4); wr(1'b0, 8'h68); idle();
    wr(1'b0, 8'h48); idle();
    tag = "R11"; wr(1'b0, 8'h0C); rd(1'b0); wr(1'b1, 8'hF0); wr(1'b0, 8'h62);
    wr(1'b0, 8'h0C); rd(1'b0); rd(1'b0);
    tag = "R7"; req_i = 8'h00; ack(); wr(1'b0, 8'h0C); rd(1'b0); rd(1'b0);
    tag = "R6"; wr(1'b0, 8'h13); wr(1'b1, 8'h88); wr(1'b1, 8'h02); wr(1'b1, 8'h00);
    req_i = 8'h81; ack(); wr(1'b0, 8'h80); ack(); ack(); wr(1'b0, 8'h0B); rd(1'b0);
    tag = "R3"; wr(1'b0, 8'h12); wr(1'b1, 8'h20); wr(1'b1, 8'h5A); rd(1'b1); ack();
    idle(); idle();
    report();
    $finish;
  end
endmodule